// File: doc/BRIEF.md
# Multiprocessor Serial Receive Filter

This block is the receive half of an asynchronous serial port that understands the multiprocessor frame format. Every frame carries a start bit, a data byte, an optional parity bit, one multiprocessor bit and a stop bit. A multiprocessor bit of 1 marks an address (ID) frame and 0 marks a data frame. The block oversamples the line on a per-base-clock tick supplied from outside. It reads each bit at the centre of its period, assembles the byte and checks parity and the stop bit. It then decides whether the frame reaches the receive buffer.

Two self-clearing filters sit behind the bit engine. The ID-wait filter is armed by a pulse. While armed, it silently drops data frames. The first ID frame disarms it and is delivered normally. The compare filter is also armed by a pulse. It checks received bytes against a programmed value, either on every frame or on ID frames only. On equality it raises a match flag and disarms itself. Parity and framing errors seen on compared frames are kept in their own pair of flags.

The configuration inputs are static levels. The arm, read and clear inputs are single-cycle pulses.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is start (0), DATA_BITS data bits, an optional parity bit, the multiprocessor bit and a stop bit. An accepted frame loads the byte into `rxByte` and its multiprocessor bit into `rxMpBit`. It also sets `rxFull` and pulses `rxValid` for one cycle. A `readAck` pulse clears `rxFull`.
- R2: One bit period is 16 base ticks when `halfRate`=0 and 8 base ticks when `halfRate`=1. Each bit is sampled at the midpoint of its period.
- R3: With `edgeStart`=0, a low line in idle starts a frame. With `edgeStart`=1, only a high-to-low transition starts a frame, so a line that stays low after a frame starts nothing.
- R4: A start bit that reads high at its midpoint is discarded and the receiver returns to idle. No frame results.
- R5: `invertRx`=1 inverts the line before all processing. `msbFirst`=1 takes the first data bit as the MSB; otherwise the first data bit is the LSB.
- R6: With `parityEn`=1, a parity bit follows the data. `parityOdd`=0 expects an even number of ones over data plus parity, and 1 expects an odd number. A mismatch on an accepted frame sets `parityFlag`.
- R7: A stop bit read as 0 on an accepted frame sets `framingFlag`.
- R8: A frame accepted while `rxFull`=1 and no `readAck` is present sets `overrunFlag`. The earlier byte in `rxByte` is kept.
- R9: While `mpieActive`=1, a frame whose multiprocessor bit is 0 is dropped. It sets neither `rxFull`, `rxValid`, `overrunFlag`, `framingFlag` nor `parityFlag`.
- R10: A frame whose multiprocessor bit is 1, received while `mpieActive`=1, clears `mpieActive` and is accepted normally. An `armMpie` pulse sets `mpieActive`.
- R11: While `cmpActive`=1, a compared frame whose byte equals `cmpData` sets `matchFlag` and clears `cmpActive`. Later frames produce no match until an `armCompare` pulse re-arms it.
- R12: With `idSelect`=0, every frame is compared. With `idSelect`=1, only frames whose multiprocessor bit is 1 are compared.
- R13: A compared frame with a parity error sets `matchParityFlag`. A compared frame with a stop bit of 0 sets `matchFramingFlag`.
- R14: A `flagClear` pulse clears `overrunFlag`, `framingFlag`, `parityFlag`, `matchFlag`, `matchParityFlag` and `matchFramingFlag`. A flag being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseTick | input | 1 | One-cycle pulse per oversampling base clock |
| rxd | input | 1 | Serial receive line |
| invertRx | input | 1 | Invert line before processing |
| halfRate | input | 1 | 8 ticks per bit instead of 16 |
| edgeStart | input | 1 | Start on falling edge instead of low level |
| msbFirst | input | 1 | First data bit is the MSB |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| idSelect | input | 1 | Compare ID frames only |
| cmpData | input | DATA_BITS | Compare value |
| armMpie | input | 1 | Pulse: arm the ID-wait filter |
| armCompare | input | 1 | Pulse: arm the compare filter |
| readAck | input | 1 | Pulse: buffered byte consumed |
| flagClear | input | 1 | Pulse: clear sticky flags |
| rxByte | output | DATA_BITS | Received byte |
| rxValid | output | 1 | One-cycle strobe on a new byte |
| rxFull | output | 1 | Buffer holds an unread byte |
| rxMpBit | output | 1 | Multiprocessor bit of the buffered byte |
| overrunFlag | output | 1 | Sticky overrun |
| framingFlag | output | 1 | Sticky framing error |
| parityFlag | output | 1 | Sticky parity error |
| mpieActive | output | 1 | ID-wait filter armed |
| cmpActive | output | 1 | Compare filter armed |
| matchFlag | output | 1 | Sticky compare match |
| matchParityFlag | output | 1 | Parity error on a compared frame |
| matchFramingFlag | output | 1 | Framing error on a compared frame |

## Verification
The line passes through one input register, and the stop bit is sampled on the tick at its midpoint. Every frame result, including buffer, flags and filter disarming, appears one clock after that tick, which lands half a bit period before the stop bit ends. Each scenario task drives the whole frame and then two idle bit periods before it samples outputs on a falling clock edge, so all results are settled and no new frame can have started. The `rxValid` strobe is counted on every falling edge, so a missing or extra delivery is seen even though the strobe lasts only one cycle.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_MPB,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftData;
    logic takeParity;
    logic takeMp;
    logic frameEnd;
    logic bitVal;
  } rxStrobe_t;

endpackage

// File: rtl/mp_rx_ctrl.sv
module mp_rx_ctrl
  import mp_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int FULL_OVS  = 16,
  parameter int HALF_OVS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baseTick,
  input  logic      rxIn,
  input  logic      halfRate,
  input  logic      edgeStart,
  input  logic      parityEn,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(FULL_OVS);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_OVS - 1);
  localparam logic [CNT_W-1:0] FULL_MID  = CNT_W'(FULL_OVS / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_MID  = CNT_W'(HALF_OVS / 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             prevRx;
  logic             startSeen;
  logic             bitDue;
  logic [CNT_W-1:0] dueCount;

  always_comb begin
    startSeen = edgeStart ? (prevRx && !rxIn) : !rxIn;
    if (state == ST_START) dueCount = halfRate ? HALF_MID : FULL_MID;
    else                   dueCount = halfRate ? HALF_LAST : FULL_LAST;
    bitDue            = baseTick && (state != ST_IDLE) && (tickCnt == dueCount);
    strobe.shiftData  = bitDue && (state == ST_DATA);
    strobe.takeParity = bitDue && (state == ST_PARITY);
    strobe.takeMp     = bitDue && (state == ST_MPB);
    strobe.frameEnd   = bitDue && (state == ST_STOP);
    strobe.bitVal     = rxIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      prevRx  <= 1'b1;
    end else if (baseTick) begin
      prevRx <= rxIn;
      if (state == ST_IDLE) begin
        if (startSeen) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
      end else if (!bitDue) begin
        tickCnt <= tickCnt + 1'b1;
      end else begin
        tickCnt <= '0;
        unique case (state)
          ST_START: begin
            bitIdx <= '0;
            state  <= rxIn ? ST_IDLE : ST_DATA;
          end
          ST_DATA: begin
            if (bitIdx == LAST_BIT) state <= parityEn ? ST_PARITY : ST_MPB;
            else                    bitIdx <= bitIdx + 1'b1;
          end
          ST_PARITY: state <= ST_MPB;
          ST_MPB:    state <= ST_STOP;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mp_rx_datapath.sv
module mp_rx_datapath
  import mp_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 msbFirst,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 idSelect,
  input  logic [DATA_BITS-1:0] cmpData,
  input  logic                 armMpie,
  input  logic                 armCompare,
  input  logic                 readAck,
  input  logic                 flagClear,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 rxFull,
  output logic                 rxMpBit,
  output logic                 overrunFlag,
  output logic                 framingFlag,
  output logic                 parityFlag,
  output logic                 mpieActive,
  output logic                 cmpActive,
  output logic                 matchFlag,
  output logic                 matchParityFlag,
  output logic                 matchFramingFlag
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 mpBitReg;
  logic                 frmErr;
  logic                 parErr;
  logic                 accept;
  logic                 bufFree;
  logic                 compareOn;
  logic                 hit;

  always_comb begin
    frmErr    = !strobe.bitVal;
    parErr    = parityEn && ((^shiftReg ^ parBit) != parityOdd);
    accept    = strobe.frameEnd && !(mpieActive && !mpBitReg);
    bufFree   = !rxFull || readAck;
    compareOn = strobe.frameEnd && cmpActive && (!idSelect || mpBitReg);
    hit       = compareOn && (shiftReg == cmpData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      mpBitReg <= 1'b0;
    end else begin
      if (strobe.shiftData) begin
        if (msbFirst) shiftReg <= {shiftReg[DATA_BITS-2:0], strobe.bitVal};
        else          shiftReg <= {strobe.bitVal, shiftReg[DATA_BITS-1:1]};
      end
      if (strobe.takeParity) parBit   <= strobe.bitVal;
      if (strobe.takeMp)     mpBitReg <= strobe.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      rxValid <= 1'b0;
      rxFull  <= 1'b0;
      rxMpBit <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (readAck) rxFull <= 1'b0;
      if (accept && bufFree) begin
        rxByte  <= shiftReg;
        rxMpBit <= mpBitReg;
        rxFull  <= 1'b1;
        rxValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunFlag <= 1'b0;
      framingFlag <= 1'b0;
      parityFlag  <= 1'b0;
    end else begin
      if (flagClear) begin
        overrunFlag <= 1'b0;
        framingFlag <= 1'b0;
        parityFlag  <= 1'b0;
      end
      if (accept) begin
        if (!bufFree) overrunFlag <= 1'b1;
        if (frmErr)   framingFlag <= 1'b1;
        if (parErr)   parityFlag  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mpieActive       <= 1'b0;
      cmpActive        <= 1'b0;
      matchFlag        <= 1'b0;
      matchParityFlag  <= 1'b0;
      matchFramingFlag <= 1'b0;
    end else begin
      if (strobe.frameEnd && mpieActive && mpBitReg) mpieActive <= 1'b0;
      if (armMpie) mpieActive <= 1'b1;
      if (flagClear) begin
        matchFlag        <= 1'b0;
        matchParityFlag  <= 1'b0;
        matchFramingFlag <= 1'b0;
      end
      if (compareOn) begin
        if (frmErr) matchFramingFlag <= 1'b1;
        if (parErr) matchParityFlag  <= 1'b1;
      end
      if (hit) begin
        matchFlag <= 1'b1;
        cmpActive <= 1'b0;
      end
      if (armCompare) cmpActive <= 1'b1;
    end
  end

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int FULL_OVS  = 16,
  parameter int HALF_OVS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baseTick,
  input  logic                 rxd,
  input  logic                 invertRx,
  input  logic                 halfRate,
  input  logic                 edgeStart,
  input  logic                 msbFirst,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 idSelect,
  input  logic [DATA_BITS-1:0] cmpData,
  input  logic                 armMpie,
  input  logic                 armCompare,
  input  logic                 readAck,
  input  logic                 flagClear,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 rxFull,
  output logic                 rxMpBit,
  output logic                 overrunFlag,
  output logic                 framingFlag,
  output logic                 parityFlag,
  output logic                 mpieActive,
  output logic                 cmpActive,
  output logic                 matchFlag,
  output logic                 matchParityFlag,
  output logic                 matchFramingFlag
);

  logic      rxReg;
  rxStrobe_t strobe;

  // Polarity applied at the input register, ahead of all decoding (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= 1'b1;
    else       rxReg <= rxd ^ invertRx;
  end

  mp_rx_ctrl #(
    .DATA_BITS(DATA_BITS),
    .FULL_OVS (FULL_OVS),
    .HALF_OVS (HALF_OVS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseTick (baseTick),
    .rxIn     (rxReg),
    .halfRate (halfRate),
    .edgeStart(edgeStart),
    .parityEn (parityEn),
    .strobe   (strobe)
  );

  mp_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) uData (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .msbFirst        (msbFirst),
    .parityEn        (parityEn),
    .parityOdd       (parityOdd),
    .idSelect        (idSelect),
    .cmpData         (cmpData),
    .armMpie         (armMpie),
    .armCompare      (armCompare),
    .readAck         (readAck),
    .flagClear       (flagClear),
    .rxByte          (rxByte),
    .rxValid         (rxValid),
    .rxFull          (rxFull),
    .rxMpBit         (rxMpBit),
    .overrunFlag     (overrunFlag),
    .framingFlag     (framingFlag),
    .parityFlag      (parityFlag),
    .mpieActive      (mpieActive),
    .cmpActive       (cmpActive),
    .matchFlag       (matchFlag),
    .matchParityFlag (matchParityFlag),
    .matchFramingFlag(matchFramingFlag)
  );

endmodule

// File: rtl/mp_rx_checker.sv
module mp_rx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 readAck,
  input logic [DATA_BITS-1:0] rxByte,
  input logic                 rxValid,
  input logic                 rxFull,
  input logic                 overrunFlag,
  input logic                 mpieActive,
  input logic                 cmpActive,
  input logic                 matchFlag
);

  // R1: a new byte is only delivered into an empty or just-read buffer
  assert_load_when_free_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!$past(rxFull) || $past(readAck)));

  // R1: the delivery strobe lasts one cycle
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8: raising overrun never disturbs the buffered byte
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $stable(rxByte));

  // R10: disarming the ID wait coincides with an accepted frame
  assert_id_accepts_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mpieActive) |-> (rxValid || overrunFlag));

  // R11: the compare filter only disarms itself on a match
  assert_match_disarm_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmpActive) |-> matchFlag);

endmodule

bind mp_uart_rx mp_rx_checker #(.DATA_BITS(DATA_BITS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .readAck    (readAck),
  .rxByte     (rxByte),
  .rxValid    (rxValid),
  .rxFull     (rxFull),
  .overrunFlag(overrunFlag),
  .mpieActive (mpieActive),
  .cmpActive  (cmpActive),
  .matchFlag  (matchFlag)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       rxd = 1'b1;
  logic       invertRx = 1'b0;
  logic       halfRate = 1'b0;
  logic       edgeStart = 1'b0;
  logic       msbFirst = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       idSelect = 1'b0;
  logic [7:0] cmpData = 8'h00;
  logic       armMpie = 1'b0;
  logic       armCompare = 1'b0;
  logic       readAck = 1'b0;
  logic       flagClear = 1'b0;
  logic [7:0] rxByte;
  logic       rxValid, rxFull, rxMpBit, overrunFlag, framingFlag, parityFlag;
  logic       mpieActive, cmpActive, matchFlag, matchParityFlag, matchFramingFlag;

  int checks = 0;
  int errors = 0;
  int validCount = 0;
  int tickDiv = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickDiv  = (tickDiv + 1) % TICK_DIV;
    baseTick = (tickDiv == 0);
    if (rxValid) validCount++;
  end

  mp_uart_rx dut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rxd(rxd),
    .invertRx(invertRx), .halfRate(halfRate), .edgeStart(edgeStart),
    .msbFirst(msbFirst), .parityEn(parityEn), .parityOdd(parityOdd),
    .idSelect(idSelect), .cmpData(cmpData), .armMpie(armMpie),
    .armCompare(armCompare), .readAck(readAck), .flagClear(flagClear),
    .rxByte(rxByte), .rxValid(rxValid), .rxFull(rxFull), .rxMpBit(rxMpBit),
    .overrunFlag(overrunFlag), .framingFlag(framingFlag), .parityFlag(parityFlag),
    .mpieActive(mpieActive), .cmpActive(cmpActive), .matchFlag(matchFlag),
    .matchParityFlag(matchParityFlag), .matchFramingFlag(matchFramingFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bitTime();
    return (halfRate ? 8 : 16) * TICK_DIV;
  endfunction

  task automatic driveBit(input logic v, input int periods);
    rxd = v ^ invertRx;
    repeat (periods * bitTime()) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic mp, input logic badPar, input logic stopV);
    driveBit(1'b0, 1);
    for (int i = 0; i < 8; i++) driveBit(msbFirst ? d[7-i] : d[i], 1);
    if (parityEn) driveBit((^d) ^ parityOdd ^ badPar, 1);
    driveBit(mp, 1);
    driveBit(stopV, 1);
    driveBit(1'b1, 2);
  endtask

  task automatic cleanSlate();
    pulse(readAck);
    pulse(flagClear);
  endtask

  task automatic testReset();
    check("R1", "rxFull after reset", rxFull, 0);
    check("R1", "rxValid after reset", rxValid, 0);
    check("R10", "mpieActive after reset", mpieActive, 0);
    check("R11", "cmpActive after reset", cmpActive, 0);
    check("R8", "overrun after reset", overrunFlag, 0);
  endtask

  task automatic testBasic();
    int v0 = validCount;
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R1", "byte lsb-first", rxByte, 8'hA5);
    check("R1", "rxFull set", rxFull, 1);
    check("R1", "one strobe", validCount - v0, 1);
    check("R1", "mp bit 0", rxMpBit, 0);
    check("R2", "16x no framing", framingFlag, 0);
    pulse(readAck);
    @(negedge clk);
    check("R1", "readAck clears full", rxFull, 0);
  endtask

  task automatic testOrderRate();
    halfRate = 1'b1; msbFirst = 1'b1; invertRx = 1'b1;
    driveBit(1'b1, 2);
    sendFrame(8'h3C, 1'b1, 1'b0, 1'b1);
    check("R5", "msb-first inverted byte", rxByte, 8'h3C);
    check("R2", "8x rate mp bit", rxMpBit, 1);
    check("R2", "8x rate no framing", framingFlag, 0);
    halfRate = 1'b0; msbFirst = 1'b0; invertRx = 1'b0;
    driveBit(1'b1, 2);
    cleanSlate();
  endtask

  task automatic testParity();
    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h96, 1'b0, 1'b0, 1'b1);
    check("R6", "even parity good", parityFlag, 0);
    check("R6", "byte with parity", rxByte, 8'h96);
    cleanSlate();
    parityOdd = 1'b1;
    sendFrame(8'h5B, 1'b0, 1'b1, 1'b1);
    check("R6", "odd parity bad", parityFlag, 1);
    check("R6", "byte with bad parity", rxByte, 8'h5B);
    parityEn = 1'b0; parityOdd = 1'b0;
    cleanSlate();
  endtask

  task automatic testFraming();
    sendFrame(8'h11, 1'b0, 1'b0, 1'b0);
    check("R7", "framing set", framingFlag, 1);
    pulse(flagClear);
    @(negedge clk);
    check("R14", "framing cleared", framingFlag, 0);
    cleanSlate();
  endtask

  task automatic testOverrun();
    sendFrame(8'h21, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    check("R8", "overrun set", overrunFlag, 1);
    check("R8", "first byte kept", rxByte, 8'h21);
    cleanSlate();
    check("R14", "overrun cleared", overrunFlag, 0);
  endtask

  task automatic testMultiproc();
    int v0;
    pulse(armMpie);
    @(negedge clk);
    check("R10", "mpie armed", mpieActive, 1);
    v0 = validCount;
    sendFrame(8'h77, 1'b0, 1'b0, 1'b0);
    check("R9", "data frame not buffered", rxFull, 0);
    check("R9", "data frame no strobe", validCount - v0, 0);
    check("R9", "data frame no framing", framingFlag, 0);
    check("R9", "still armed", mpieActive, 1);
    sendFrame(8'h88, 1'b1, 1'b0, 1'b1);
    check("R10", "id frame buffered", rxByte, 8'h88);
    check("R10", "id frame full", rxFull, 1);
    check("R10", "mpie self-cleared", mpieActive, 0);
    cleanSlate();
  endtask

  task automatic testCompare();
    cmpData = 8'h42; idSelect = 1'b0;
    pulse(armCompare);
    sendFrame(8'h41, 1'b0, 1'b0, 1'b1);
    check("R11", "no match on 41", matchFlag, 0);
    check("R11", "still armed", cmpActive, 1);
    pulse(readAck);
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1);
    check("R12", "match on data frame when idSelect=0", matchFlag, 1);
    check("R11", "compare self-cleared", cmpActive, 0);
    cleanSlate();
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1);
    check("R11", "no match after disarm", matchFlag, 0);
    cleanSlate();
  endtask

  task automatic testIdCompare();
    idSelect = 1'b1;
    pulse(armCompare);
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1);
    check("R12", "data frame not compared", matchFlag, 0);
    check("R12", "armed after data frame", cmpActive, 1);
    pulse(readAck);
    parityEn = 1'b1;
    sendFrame(8'h42, 1'b1, 1'b1, 1'b1);
    check("R12", "id frame matched", matchFlag, 1);
    check("R13", "compare parity error", matchParityFlag, 1);
    check("R13", "no compare framing error", matchFramingFlag, 0);
    parityEn = 1'b0;
    cleanSlate();
    pulse(armCompare);
    sendFrame(8'h42, 1'b1, 1'b0, 1'b0);
    check("R13", "compare framing error", matchFramingFlag, 1);
    check("R14", "compare parity cleared", matchParityFlag, 0);
    idSelect = 1'b0;
    cleanSlate();
  endtask

  task automatic testGlitch();
    int v0 = validCount;
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    driveBit(1'b1, 3);
    check("R4", "glitch gives no strobe", validCount - v0, 0);
    check("R4", "glitch gives no byte", rxFull, 0);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b1);
    check("R4", "frame after glitch", rxByte, 8'hC3);
    cleanSlate();
  endtask

  task automatic longLow();
    driveBit(1'b0, 10);
    driveBit(1'b0, 1);
    driveBit(1'b0, 14);
    driveBit(1'b1, 14);
  endtask

  task automatic testStartMode();
    int v0;
    edgeStart = 1'b0;
    longLow();
    check("R3", "level start restarts on low line", overrunFlag, 1);
    cleanSlate();
    edgeStart = 1'b1;
    driveBit(1'b1, 2);
    v0 = validCount;
    longLow();
    check("R3", "edge start single frame", validCount - v0, 1);
    check("R3", "edge start no overrun", overrunFlag, 0);
    check("R7", "edge start framing", framingFlag, 1);
    edgeStart = 1'b0;
    cleanSlate();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    driveBit(1'b1, 1);
    testBasic();
    testOrderRate();
    testParity();
    testFraming();
    testOverrun();
    testMultiproc();
    testCompare();
    testIdCompare();
    testGlitch();
    testStartMode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule